// File: doc/BRIEF.md
# Colour Table Loader and Pixel Depth Decoder

This block is the host-facing write side of a colour lookup table. Software first writes a starting table index. It then streams colour components one byte at a time, in the order red, green, blue. Each third byte completes a 24-bit entry. The block presents that entry on a palette write port for a single cycle and then steps the index to the next slot, so a whole table can be loaded with one index write followed by a run of component writes.

A second register selects the pixel depth. The host writes a control byte, the block masks it, and five recognised codes choose one of five depth modes. Any other code leaves the current mode in place. Reads from the register window always return zero.

The component sequencer is a three-state machine: `PH_RED`, `PH_GREEN` and `PH_BLUE`. A component write moves it `PH_RED`→`PH_GREEN`, `PH_GREEN`→`PH_BLUE`, and `PH_BLUE`→`PH_RED`; the last of these commits the entry. An index write sends the machine from any state back to `PH_RED`. Reset puts it in `PH_RED`.

Top module: `clut_loader`

## Requirements
- R1: After reset the index is 0, the sequencer is in `PH_RED`, `depth_mode` is 0 (1 bpp) and `pal_we` is low.
- R2: A write to byte offset 0x00 loads the index from `wdata[7:0]` and returns the sequencer to `PH_RED`, which discards any partial entry.
- R3: Writes to byte offset 0x10 take `wdata[7:0]` as red, then green, then blue. In the cycle after the blue write, `pal_we` is high, `pal_rgb` = {red, green, blue} with red in bits [23:16] and blue in [7:0], and `pal_idx` is the index in use before the commit.
- R4: After each commit the index increases by one, and it wraps from 255 to 0.
- R5: A write to byte offset 0x20 masks `wdata[7:0]` with 0x9F and then sets `depth_mode`: 0x80→0 (1 bpp), 0x88→1 (2 bpp), 0x90→2 (4 bpp), 0x98→3 (8 bpp), 0x9C→4 (24 bpp). The new mode appears in the cycle after the write.
- R6: A write to 0x20 whose masked value is none of the five codes leaves `depth_mode` unchanged.
- R7: `pal_we` is high for exactly one cycle per third component write and is never high at any other time.
- R8: `rdata` is always zero, and a read changes no state.
- R9: Writes to any offset other than 0x00, 0x10 and 0x20 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset within the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, always zero |
| pal_we | output | 1 | One-cycle strobe that writes a table entry |
| pal_idx | output | 8 | Table index for the entry being written |
| pal_rgb | output | 24 | Entry colour, red in bits [23:16] |
| depth_mode | output | 3 | Selected pixel depth, 0 to 4 |

## Verification
Some properties are checked by assertions on every clock. These are: a strobe never follows a strobe, each commit advances the index by exactly one, the mode stays in the range 0 to 4, an unrecognised control code leaves the mode as it was, and the read data is zero. Other behaviour only the bench scenarios can show. That covers the byte order inside a committed entry, how a mid-entry index write discards the partial colour, the wrap from 255 to 0, and the mask that turns codes with stray upper bits into valid depths. A behavioural model is compared against every output on every cycle to cover these.

// File: rtl/clut_pkg.sv
package clut_pkg;
    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_t;

    typedef enum logic [2:0] {
        DEPTH_1  = 3'd0,
        DEPTH_2  = 3'd1,
        DEPTH_4  = 3'd2,
        DEPTH_8  = 3'd3,
        DEPTH_24 = 3'd4
    } depth_t;

    localparam logic [7:0] CTRL_MASK = 8'h9F;
    localparam logic [7:0] CODE_D1   = 8'h80;
    localparam logic [7:0] CODE_D2   = 8'h88;
    localparam logic [7:0] CODE_D4   = 8'h90;
    localparam logic [7:0] CODE_D8   = 8'h98;
    localparam logic [7:0] CODE_D24  = 8'h9C;
endpackage

// File: rtl/clut_phase_fsm.sv
module clut_phase_fsm
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idx_load,
    input  logic [IDX_W-1:0]    idx_val,
    input  logic                comp_wr,
    input  logic [COMP_W-1:0]   comp_val,
    output logic                pal_we,
    output logic [IDX_W-1:0]    pal_idx,
    output logic [3*COMP_W-1:0] pal_rgb
);
    phase_t             state_q, state_d;
    logic [COMP_W-1:0]  red_q, grn_q;
    logic [IDX_W-1:0]   index_q;
    logic               commit;

    assign commit = comp_wr && (state_q == PH_BLUE);

    always_comb begin
        state_d = state_q;
        if (idx_load) begin
            state_d = PH_RED;
        end else if (comp_wr) begin
            unique case (state_q)
                PH_RED:   state_d = PH_GREEN;
                PH_GREEN: state_d = PH_BLUE;
                PH_BLUE:  state_d = PH_RED;
                default:  state_d = PH_RED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_RED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            red_q   <= '0;
            grn_q   <= '0;
            index_q <= '0;
            pal_we  <= 1'b0;
            pal_idx <= '0;
            pal_rgb <= '0;
        end else begin
            pal_we <= commit;
            if (idx_load) begin
                index_q <= idx_val;
            end else if (comp_wr) begin
                unique case (state_q)
                    PH_RED:   red_q <= comp_val;
                    PH_GREEN: grn_q <= comp_val;
                    PH_BLUE: begin
                        pal_idx <= index_q;
                        pal_rgb <= {red_q, grn_q, comp_val};
                        index_q <= index_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_we_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |=> !pal_we);
    assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (index_q == $past(index_q) + 1'b1) && (pal_idx == $past(index_q)));
    assert_blue_leads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |-> ($past(state_q) == PH_BLUE) && (state_q == PH_RED));
endmodule

// File: rtl/clut_depth_decode.sv
module clut_depth_decode
    import clut_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_val,
    output logic [2:0] depth_mode
);
    logic [7:0] code;
    logic       hit;
    depth_t     sel;

    assign code = ctrl_val & CTRL_MASK;

    always_comb begin
        hit = 1'b1;
        sel = DEPTH_1;
        unique case (code)
            CODE_D1:  sel = DEPTH_1;
            CODE_D2:  sel = DEPTH_2;
            CODE_D4:  sel = DEPTH_4;
            CODE_D8:  sel = DEPTH_8;
            CODE_D24: sel = DEPTH_24;
            default:  hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              depth_mode <= DEPTH_1;
        else if (ctrl_wr && hit) depth_mode <= sel;
    end

    assert_mode_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        depth_mode <= 3'd4);
    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && code != CODE_D1 && code != CODE_D2 && code != CODE_D4
         && code != CODE_D8 && code != CODE_D24) |=> $stable(depth_mode));
endmodule

// File: rtl/clut_loader.sv
module clut_loader
    import clut_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                pal_we,
    output logic [IDX_W-1:0]    pal_idx,
    output logic [3*COMP_W-1:0] pal_rgb,
    output logic [2:0]          depth_mode
);
    localparam logic [ADDR_W-1:0] OFS_INDEX = ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] OFS_COMP  = ADDR_W'('h10);
    localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'('h20);

    logic idx_load, comp_wr, ctrl_wr, rd_unused;

    assign idx_load  = wr_en && (addr == OFS_INDEX);
    assign comp_wr   = wr_en && (addr == OFS_COMP);
    assign ctrl_wr   = wr_en && (addr == OFS_CTRL);
    assign rd_unused = rd_en;
    assign rdata     = '0;

    clut_phase_fsm #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_load (idx_load),
        .idx_val  (wdata[IDX_W-1:0]),
        .comp_wr  (comp_wr),
        .comp_val (wdata[COMP_W-1:0]),
        .pal_we   (pal_we),
        .pal_idx  (pal_idx),
        .pal_rgb  (pal_rgb)
    );

    clut_depth_decode u_depth (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_val   (wdata[7:0]),
        .depth_mode (depth_mode)
    );

    always_comb begin
        assert_rdata_zero_R8: assert (rdata == '0 || rd_unused);
    end
endmodule

// File: tb/clut_loader_tb.sv
module clut_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pal_we;
    logic [7:0]  pal_idx;
    logic [23:0] pal_rgb;
    logic [2:0]  depth_mode;

    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    clut_loader dut_i (.*);

    // behavioural reference model
    int m_idx, m_cnt, m_mode;
    int m_comp[3];
    bit e_we;
    int e_idx, e_rgb;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = 0; m_cnt = 0; m_mode = 0; e_we = 0; e_idx = 0; e_rgb = 0;
        end else begin
            e_we = 0;
            if (wr_en && addr == 8'h00) begin
                m_idx = wdata[7:0]; m_cnt = 0;
            end else if (wr_en && addr == 8'h10) begin
                m_comp[m_cnt] = wdata[7:0];
                m_cnt = m_cnt + 1;
                if (m_cnt == 3) begin
                    e_we = 1; e_idx = m_idx;
                    e_rgb = (m_comp[0] << 16) | (m_comp[1] << 8) | m_comp[2];
                    m_idx = (m_idx + 1) % 256; m_cnt = 0;
                end
            end else if (wr_en && addr == 8'h20) begin
                case (wdata[7:0] & 8'h9F)
                    8'h80: m_mode = 0;
                    8'h88: m_mode = 1;
                    8'h90: m_mode = 2;
                    8'h98: m_mode = 3;
                    8'h9C: m_mode = 4;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) if (rst_n) begin
        chk("R7 strobe", int'(pal_we), int'(e_we));
        if (e_we) begin
            chk("R4 index", int'(pal_idx), e_idx);
            chk("R3 colour", int'(pal_rgb), e_rgb);
        end
        chk("R5/R6 mode", int'(depth_mode), m_mode);
        chk("R8 rdata", int'(rdata), 0);
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'hFF; wdata = 32'hDEAD_BEEF;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // expects the strobe in the cycle after the third write
    task automatic entry(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                         input int exp_idx, input string req);
        wr(8'h10, {24'h0, r});
        wr(8'h10, {24'h0, g});
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h10; wdata = {24'hABCDEF, b};
        @(negedge clk);
        wr_en = 1'b0; addr = 8'hFF;
        chk(req, int'(pal_we), 1);
        chk(req, int'(pal_idx), exp_idx);
        chk(req, int'(pal_rgb), {r, g, b});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", int'(depth_mode), 0);
        chk("R1 we", int'(pal_we), 0);
        entry(8'h11, 8'h22, 8'h33, 0, "R1 idx0");
        // R3 ordering, R4 auto increment
        entry(8'hA1, 8'hB2, 8'hC3, 1, "R3 order");
        entry(8'h01, 8'h02, 8'h03, 2, "R4 step");
        // R2 index load, with partial entry discarded
        wr(8'h10, 32'h55);
        wr(8'h00, 32'h1234_5640);
        entry(8'h66, 8'h77, 8'h88, 8'h40, "R2 restart");
        // R4 wrap
        wr(8'h00, 32'hFF);
        entry(8'h0F, 8'hF0, 8'h5A, 255, "R4 wrap hi");
        entry(8'h12, 8'h34, 8'h56, 0, "R4 wrap lo");
        // R5 codes, including masked bits
        wr(8'h20, 32'h88); chk("R5 2bpp", int'(depth_mode), 1);
        wr(8'h20, 32'hF0); chk("R5 4bpp mask", int'(depth_mode), 2);
        wr(8'h20, 32'h98); chk("R5 8bpp", int'(depth_mode), 3);
        wr(8'h20, 32'hFC); chk("R5 24bpp mask", int'(depth_mode), 4);
        // R6 unknown codes
        wr(8'h20, 32'h84); chk("R6 hold", int'(depth_mode), 4);
        wr(8'h20, 32'h00); chk("R6 hold zero", int'(depth_mode), 4);
        wr(8'h20, 32'hE0); chk("R5 1bpp mask", int'(depth_mode), 0);
        // R9 other offsets ignored
        wr(8'h00, 32'h10);
        wr(8'h10, 32'h01);
        wr(8'h14, 32'h99);
        wr(8'h30, 32'h9C); chk("R9 mode", int'(depth_mode), 0);
        wr(8'h10, 32'h02);
        // R8 reads have no effect
        rd(8'h10);
        chk("R8 rdata", int'(rdata), 0);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h10; wdata = 32'h03;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'hFF;
        chk("R9 idx", int'(pal_idx), 8'h10);
        chk("R9 rgb", int'(pal_rgb), 24'h010203);
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule